// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block collects 64 level-sensitive interrupt sources. It holds their pending, enable and routing state behind a small 32-bit register bus addressed by word index. Each source is routed either to a fast request line or to a normal request line. Normal requests also carry a 4-bit priority and are held back by a programmable threshold. Software can read the highest-priority normal source or the lowest-numbered fast source from a vector word. That read acknowledges the source by clearing its pending bit.

Every 64-bit state vector is split into a high word (sources 63..32) and a low word (sources 31..0) at adjacent indices. Enables can also be set or cleared one source at a time by writing the source number. The bus is a single-cycle strobe: read data is combinational on the address, and every write or acknowledge takes effect at the next rising clock edge. The asynchronous reset is released to the state registers through a two-stage synchronizer, so state starts to move on the third rising edge after `rst_n` goes high.

Top module: `vic_intc`

## Requirements
- R1: A write to word 2 sets the enable bit of the source given by bits 5:0 of the data, and a write to word 3 clears that bit; both words read as zero.
- R2: Enable (high/low at words 4/5), type (6/7) and pending (18/19) read back their vector halves. Writes to 4..7 replace a half, and writes to force words 20/21 replace the pending high/low half directly.
- R3: `irq_fast` is high exactly when some source is pending, enabled and has its type bit set to 1 (fast).
- R4: With the 5-bit threshold (word 1) at 0x1F, `irq_normal` is high whenever any pending, enabled source has type 0. Otherwise it is high only if such a source has a priority strictly above the threshold.
- R5: Priority words 8..15 each hold eight 4-bit fields. Word 15 serves sources 0..7 and word 8 serves 56..63, and source n sits at bits 4*(n%8)+3 .. 4*(n%8).
- R6: Reading word 16 returns (index<<16)|priority of the pending enabled normal source with the highest priority, with ties going to the higher index, and clears that pending bit. It returns 0xFFFFFFFF when there is none. The threshold does not apply.
- R7: Reading word 17 returns the lowest index among pending enabled fast sources and clears that pending bit, or returns 0xFFFFFFFF when there is none.
- R8: When a source input level differs from its value sampled at the previous edge, the pending bit takes the new level at that edge.
- R9: After reset: pending, enable, type, control and every priority are zero, the threshold reads 0x1F and both request outputs are low.
- R10: Words 22/23 read pending&enable&~type (high/low) and 24/25 read pending&enable&type. Writes to 16..19 and 22..25, and to the vector table region 64..191, change nothing. Unmapped words read zero.
- R11: The control word 0 stores only bits 24 and 22..18 of a write; all other bits read zero.
- R12: An acknowledge by vector read wins over an input level change of the same source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Source levels, bit n is source n |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_normal | output | 1 | Normal request after threshold gating |
| irq_fast | output | 1 | Fast request |

## Verification
On every cycle the assertions tie the vector reads to the request lines. A fast vector read returns a number exactly when `irq_fast` is high. A normal vector read that returns nothing implies `irq_normal` is low, and the reported priority set against the threshold decides the line. Each acknowledged source and each force write must show up in the pending state one edge later, and the enable-by-number words must read zero. Some behaviour only the bench scenarios can show: the priority field layout, tie-breaking toward the higher index, acknowledge winning over a same-cycle input edge, the threshold boundary where equal priority does not raise the line, and the ignored writes to read-only and vector-table words.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // word indices of the register map (decoded by software)
  localparam int VIC_W_CTRL     = 0;
  localparam int VIC_W_MASK     = 1;
  localparam int VIC_W_ENSET    = 2;
  localparam int VIC_W_ENCLR    = 3;
  localparam int VIC_W_EN_HI    = 4;
  localparam int VIC_W_EN_LO    = 5;
  localparam int VIC_W_TYP_HI   = 6;
  localparam int VIC_W_TYP_LO   = 7;
  localparam int VIC_W_PRIO_LO  = 8;
  localparam int VIC_W_PRIO_HI  = 15;
  localparam int VIC_W_NVEC     = 16;
  localparam int VIC_W_FVEC     = 17;
  localparam int VIC_W_PND_HI   = 18;
  localparam int VIC_W_PND_LO   = 19;
  localparam int VIC_W_FRC_HI   = 20;
  localparam int VIC_W_FRC_LO   = 21;
  localparam int VIC_W_NPND_HI  = 22;
  localparam int VIC_W_NPND_LO  = 23;
  localparam int VIC_W_FPND_HI  = 24;
  localparam int VIC_W_FPND_LO  = 25;

  localparam logic [31:0] VIC_CTRL_KEEP = 32'h017C_0000;

  typedef enum logic [1:0] {
    ACK_NONE   = 2'd0,
    ACK_NORMAL = 2'd1,
    ACK_FAST   = 2'd2
  } vic_ack_e;
endpackage

// File: rtl/vic_rst_sync.sv
module vic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int DATA_W = 32,
  parameter int NUM_SRC = 2 * DATA_W,
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               frc_hi_we,
  input  logic               frc_lo_we,
  input  logic [DATA_W-1:0]  frc_data,
  input  logic               ack_we,
  input  logic [IDX_W-1:0]   ack_idx,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] level_chg;

  assign level_chg = src_in ^ src_q;

  // next state: level edges, then force, then acknowledge (highest precedence)
  always_comb begin
    pend_d = (pend_q & ~level_chg) | (src_in & level_chg);
    if (frc_hi_we) pend_d[NUM_SRC-1:DATA_W] = frc_data;
    if (frc_lo_we) pend_d[DATA_W-1:0]       = frc_data;
    if (ack_we)    pend_d[ack_idx]          = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/vic_norm_arb.sv
module vic_norm_arb #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W = 4,
  parameter int MASK_W = 5,
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [MASK_W-1:0]         thresh,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio,
  output logic                      raise
);
  logic [PRIO_W-1:0] prio_a [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // ascending scan with >= so equal priority goes to the higher index
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!found || prio_a[i] >= win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_a[i];
      end
    end
  end

  assign raise = found &&
                 ((thresh == '1) || ({{(MASK_W-PRIO_W){1'b0}}, win_prio} > thresh));
endmodule

// File: rtl/vic_fast_pick.sv
module vic_fast_pick #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   pick_idx
);
  assign found = |req;

  always_comb begin
    pick_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) pick_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_intc.sv
module vic_intc
  import vic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int MASK_W = 5,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] src_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_normal,
  output logic                irq_fast
);
  localparam int NUM_SRC    = 2 * DATA_W;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = NUM_SRC / PER_WORD;
  localparam int VEC_SHIFT  = 16;

  logic rst_i;

  logic [DATA_W-1:0]  ctrl_q;
  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] typ_q, typ_d;
  logic [DATA_W-1:0]  prio_q [PRIO_WORDS];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0] pend_q;

  logic ctrl_we, mask_we, en_we, typ_we, frc_hi_we, frc_lo_we;
  logic [PRIO_WORDS-1:0] prio_we;
  logic wr_en, rd_en;
  int   aidx;
  vic_ack_e ack_kind;
  logic [IDX_W-1:0] ack_idx;

  logic [NUM_SRC-1:0] norm_req, fast_req;
  logic             n_found, f_found, n_raise;
  logic [IDX_W-1:0] n_idx, f_idx;
  logic [PRIO_W-1:0] n_prio;
  logic [DATA_W-1:0] nvec_val, fvec_val;

  vic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign aidx  = int'(bus_addr);

  // write decode and next-state of enable/type vectors
  always_comb begin
    ctrl_we   = 1'b0;
    mask_we   = 1'b0;
    en_we     = 1'b0;
    typ_we    = 1'b0;
    frc_hi_we = 1'b0;
    frc_lo_we = 1'b0;
    en_d      = en_q;
    typ_d     = typ_q;
    if (wr_en) begin
      case (aidx)
        VIC_W_CTRL:   ctrl_we = 1'b1;
        VIC_W_MASK:   mask_we = 1'b1;
        VIC_W_ENSET: begin
          en_we = 1'b1;
          en_d[bus_wdata[IDX_W-1:0]] = 1'b1;
        end
        VIC_W_ENCLR: begin
          en_we = 1'b1;
          en_d[bus_wdata[IDX_W-1:0]] = 1'b0;
        end
        VIC_W_EN_HI: begin
          en_we = 1'b1;
          en_d[NUM_SRC-1:DATA_W] = bus_wdata;
        end
        VIC_W_EN_LO: begin
          en_we = 1'b1;
          en_d[DATA_W-1:0] = bus_wdata;
        end
        VIC_W_TYP_HI: begin
          typ_we = 1'b1;
          typ_d[NUM_SRC-1:DATA_W] = bus_wdata;
        end
        VIC_W_TYP_LO: begin
          typ_we = 1'b1;
          typ_d[DATA_W-1:0] = bus_wdata;
        end
        VIC_W_FRC_HI: frc_hi_we = 1'b1;
        VIC_W_FRC_LO: frc_lo_we = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio_we
    assign prio_we[k] = wr_en && (aidx == VIC_W_PRIO_HI - k);
  end

  // acknowledge by vector read
  always_comb begin
    ack_kind = ACK_NONE;
    if (rd_en && aidx == VIC_W_NVEC && n_found) ack_kind = ACK_NORMAL;
    if (rd_en && aidx == VIC_W_FVEC && f_found) ack_kind = ACK_FAST;
  end
  assign ack_idx = (ack_kind == ACK_FAST) ? f_idx : n_idx;

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      typ_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= bus_wdata & DATA_W'(VIC_CTRL_KEEP);
      if (mask_we) mask_q <= bus_wdata[MASK_W-1:0];
      if (en_we)   en_q   <= en_d;
      if (typ_we)  typ_q  <= typ_d;
    end
  end

  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_prio
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i)          prio_q[k] <= '0;
      else if (prio_we[k]) prio_q[k] <= bus_wdata;
    end
    assign prio_flat[k*DATA_W +: DATA_W] = prio_q[k];
  end

  vic_pending #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_i),
    .src_in    (src_in),
    .frc_hi_we (frc_hi_we),
    .frc_lo_we (frc_lo_we),
    .frc_data  (bus_wdata),
    .ack_we    (ack_kind != ACK_NONE),
    .ack_idx   (ack_idx),
    .pend_q    (pend_q)
  );

  assign norm_req = pend_q & en_q & ~typ_q;
  assign fast_req = pend_q & en_q & typ_q;

  vic_norm_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_arb (
    .req       (norm_req),
    .prio_flat (prio_flat),
    .thresh    (mask_q),
    .found     (n_found),
    .win_idx   (n_idx),
    .win_prio  (n_prio),
    .raise     (n_raise)
  );

  vic_fast_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_fast (
    .req      (fast_req),
    .found    (f_found),
    .pick_idx (f_idx)
  );

  assign irq_normal = n_raise;
  assign irq_fast   = f_found;

  assign nvec_val = n_found ? ((DATA_W'(n_idx) << VEC_SHIFT) | DATA_W'(n_prio)) : '1;
  assign fvec_val = f_found ? DATA_W'(f_idx) : '1;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (aidx)
      VIC_W_CTRL:    bus_rdata = ctrl_q;
      VIC_W_MASK:    bus_rdata = DATA_W'(mask_q);
      VIC_W_EN_HI:   bus_rdata = en_q[NUM_SRC-1:DATA_W];
      VIC_W_EN_LO:   bus_rdata = en_q[DATA_W-1:0];
      VIC_W_TYP_HI:  bus_rdata = typ_q[NUM_SRC-1:DATA_W];
      VIC_W_TYP_LO:  bus_rdata = typ_q[DATA_W-1:0];
      VIC_W_NVEC:    bus_rdata = nvec_val;
      VIC_W_FVEC:    bus_rdata = fvec_val;
      VIC_W_PND_HI:  bus_rdata = pend_q[NUM_SRC-1:DATA_W];
      VIC_W_PND_LO:  bus_rdata = pend_q[DATA_W-1:0];
      VIC_W_NPND_HI: bus_rdata = norm_req[NUM_SRC-1:DATA_W];
      VIC_W_NPND_LO: bus_rdata = norm_req[DATA_W-1:0];
      VIC_W_FPND_HI: bus_rdata = fast_req[NUM_SRC-1:DATA_W];
      VIC_W_FPND_LO: bus_rdata = fast_req[DATA_W-1:0];
      default: begin
        for (int k = 0; k < PRIO_WORDS; k++) begin
          if (aidx == VIC_W_PRIO_HI - k) bus_rdata = prio_q[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/vic_intc_chk.sv
module vic_intc_chk #(
  parameter int DATA_W = 32,
  parameter int MASK_W = 5,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_i,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_normal,
  input logic                irq_fast,
  input logic [2*DATA_W-1:0] pend_q,
  input logic [MASK_W-1:0]   mask_q
);
  logic rd_nvec, rd_fvec, vec_none;
  assign rd_nvec  = bus_sel && !bus_wr && bus_addr == ADDR_W'(16);
  assign rd_fvec  = bus_sel && !bus_wr && bus_addr == ADDR_W'(17);
  assign vec_none = (bus_rdata == '1);

  AST_ENNUM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_i)
    bus_sel && !bus_wr && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3)) |-> bus_rdata == '0); // R1
  AST_FORCE_LO_LANDS: assert property (@(posedge clk) disable iff (!rst_i)
    bus_sel && bus_wr && bus_addr == ADDR_W'(21) |=> pend_q[DATA_W-1:0] == $past(bus_wdata)); // R2
  AST_FAST_LINE_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_i)
    rd_fvec |-> (!vec_none == irq_fast)); // R3
  AST_NORM_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    rd_nvec && vec_none |-> !irq_normal); // R4
  AST_NORM_OPEN_THRESH: assert property (@(posedge clk) disable iff (!rst_i)
    rd_nvec && !vec_none && mask_q == '1 |-> irq_normal); // R4
  AST_NORM_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_i)
    rd_nvec && !vec_none && mask_q != '1 && MASK_W'(bus_rdata[3:0]) <= mask_q |-> !irq_normal); // R4
  AST_NORM_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    rd_nvec && !vec_none |=> !pend_q[$past(bus_rdata[21:16])]); // R6
  AST_FAST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    rd_fvec && !vec_none |=> !pend_q[$past(bus_rdata[5:0])]); // R7
endmodule

bind vic_intc vic_intc_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_normal (irq_normal),
  .irq_fast   (irq_fast),
  .pend_q     (pend_q),
  .mask_q     (mask_q)
);

// File: tb/tb_vic_intc.sv
module tb_vic_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_in;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_normal, irq_fast;

  int checks = 0;
  int fails = 0;
  string cur_req = "R9";

  // reference model state
  logic [63:0] m_pend, m_en, m_typ, m_srcq;
  int          m_prio [64];
  int          m_mask;
  logic [31:0] m_ctrl;
  int          rst_cnt;

  always #10 clk = ~clk;

  vic_intc dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_normal (irq_normal),
    .irq_fast   (irq_fast)
  );

  function automatic void m_reset();
    m_pend = '0; m_en = '0; m_typ = '0; m_srcq = '0;
    m_mask = 31; m_ctrl = '0;
    for (int i = 0; i < 64; i++) m_prio[i] = 0;
  endfunction

  function automatic logic [63:0] m_nreq();
    return m_pend & m_en & ~m_typ;
  endfunction

  function automatic logic [63:0] m_freq();
    return m_pend & m_en & m_typ;
  endfunction

  function automatic int m_nvec_idx();
    int best = -1;
    int bi = -1;
    logic [63:0] r = m_nreq();
    for (int i = 63; i >= 0; i--)
      if (r[i] && m_prio[i] > best) begin best = m_prio[i]; bi = i; end
    return bi;
  endfunction

  function automatic int m_fvec_idx();
    logic [63:0] r = m_freq();
    for (int i = 0; i < 64; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_irq_normal();
    logic [63:0] r = m_nreq();
    if (r == 0) return 1'b0;
    if (m_mask == 31) return 1'b1;
    for (int i = 0; i < 64; i++) if (r[i] && m_prio[i] > m_mask) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(int a);
    logic [31:0] v = '0;
    int n;
    case (a)
      0: v = m_ctrl;
      1: v = 32'(m_mask);
      4: v = m_en[63:32];
      5: v = m_en[31:0];
      6: v = m_typ[63:32];
      7: v = m_typ[31:0];
      16: begin
        n = m_nvec_idx();
        v = (n < 0) ? 32'hFFFF_FFFF : ((32'(n) << 16) | 32'(m_prio[n]));
      end
      17: begin
        n = m_fvec_idx();
        v = (n < 0) ? 32'hFFFF_FFFF : 32'(n);
      end
      18: v = m_pend[63:32];
      19: v = m_pend[31:0];
      22: v = m_nreq() >> 32;
      23: v = m_nreq() & 64'hFFFF_FFFF;
      24: v = m_freq() >> 32;
      25: v = m_freq() & 64'hFFFF_FFFF;
      default: begin
        if (a >= 8 && a <= 15)
          for (int j = 0; j < 8; j++) v[4*j +: 4] = 4'(m_prio[(15 - a) * 8 + j]);
      end
    endcase
    return v;
  endfunction

  function automatic void model_step();
    logic [63:0] nxt;
    int a = int'(bus_addr);
    int ni, fi;
    if (!rst_n) begin m_reset(); rst_cnt = 0; return; end
    if (rst_cnt < 2) begin rst_cnt++; return; end
    ni = m_nvec_idx();
    fi = m_fvec_idx();
    nxt = m_pend;
    for (int i = 0; i < 64; i++) if (src_in[i] != m_srcq[i]) nxt[i] = src_in[i];
    if (bus_sel && bus_wr && a == 20) nxt[63:32] = bus_wdata;
    if (bus_sel && bus_wr && a == 21) nxt[31:0] = bus_wdata;
    if (bus_sel && !bus_wr && a == 16 && ni >= 0) nxt[ni] = 1'b0;
    if (bus_sel && !bus_wr && a == 17 && fi >= 0) nxt[fi] = 1'b0;
    if (bus_sel && bus_wr) begin
      case (a)
        0: m_ctrl = bus_wdata & 32'h017C_0000;
        1: m_mask = int'(bus_wdata[4:0]);
        2: m_en[bus_wdata[5:0]] = 1'b1;
        3: m_en[bus_wdata[5:0]] = 1'b0;
        4: m_en[63:32] = bus_wdata;
        5: m_en[31:0] = bus_wdata;
        6: m_typ[63:32] = bus_wdata;
        7: m_typ[31:0] = bus_wdata;
        default: begin
          if (a >= 8 && a <= 15)
            for (int j = 0; j < 8; j++) m_prio[(15 - a) * 8 + j] = int'(bus_wdata[4*j +: 4]);
        end
      endcase
    end
    m_pend = nxt;
    m_srcq = src_in;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // inputs are set just after a falling edge; compare 5 ns before the rising edge
  task automatic tick();
    #5;
    chk("irq_fast", {31'b0, irq_fast}, {31'b0, (m_freq() != 0)});
    chk("irq_normal", {31'b0, irq_normal}, {31'b0, exp_irq_normal()});
    if (bus_sel && !bus_wr) chk($sformatf("rdata[w%0d]", bus_addr), bus_rdata, exp_read(int'(bus_addr)));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(int a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a); bus_wdata = '0;
    tick();
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src_in = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_reset(); rst_cnt = 0;
    @(negedge clk); @(negedge clk);
    tick();
    rst_n = 1'b1;
    idle(3);

    cur_req = "R9";  // reset values of every mapped word
    for (int a = 0; a <= 25; a++) rd(a);

    cur_req = "R11";
    wr(0, 32'hFFFF_FFFF); rd(0);
    wr(0, 32'h0040_0000); rd(0);

    cur_req = "R1";
    wr(2, 32'h0000_00C5); wr(2, 32'd40);
    rd(5); rd(4); rd(2); rd(3);
    wr(3, 32'h0000_0045); rd(5); rd(4);

    cur_req = "R2";
    wr(4, 32'hA5A5_0F0F); wr(5, 32'h1234_5678); wr(6, 32'h8000_0001); wr(7, 32'h00FF_0000);
    rd(4); rd(5); rd(6); rd(7);
    wr(21, 32'h0000_00F0); wr(20, 32'h8000_0001);
    rd(18); rd(19); rd(22); rd(23); rd(24); rd(25);
    wr(20, 32'h0); wr(21, 32'h0); wr(6, 32'h0); wr(7, 32'h0);

    cur_req = "R8";
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    src_in = (64'd1 << 3) | (64'd1 << 40);
    tick(); rd(19); rd(18);
    src_in = (64'd1 << 40);
    tick(); rd(19); rd(18);
    src_in = '0;
    idle(2); rd(18);

    cur_req = "R3";
    wr(7, 32'h0000_0008);
    src_in = (64'd1 << 3) | (64'd1 << 9);
    idle(2); rd(25); rd(23);

    cur_req = "R7";
    rd(17); rd(17);
    wr(7, 32'h0000_0410); wr(21, 32'h0000_0410);
    rd(17); rd(17); rd(17);
    src_in = '0; wr(7, 32'h0); idle(2); wr(21, 32'h0);

    cur_req = "R5";
    wr(15, 32'h0000_0030); wr(14, 32'h0000_0500); wr(8, 32'h7000_0000);
    rd(15); rd(14); rd(8); rd(9);

    cur_req = "R4";
    wr(21, 32'h0000_0402); wr(20, 32'h8000_0000);
    wr(1, 32'hFFFF_FFFF); idle(1);
    wr(1, 32'd7); idle(1);
    wr(1, 32'd6); idle(1);
    wr(1, 32'd20); rd(1);
    wr(1, 32'd2); idle(1);

    cur_req = "R6";
    wr(1, 32'h1F);
    rd(16); rd(16); rd(16); rd(16);
    wr(21, 32'h0000_0044);
    rd(16); rd(16); rd(16);

    cur_req = "R10";
    wr(21, 32'h0000_0F00); wr(7, 32'h0000_0C00);
    for (int a = 22; a <= 25; a++) wr(a, 32'hFFFF_FFFF);
    wr(18, 32'hFFFF_FFFF); wr(19, 32'h0);
    wr(64, 32'hFFFF_FFFF); wr(191, 32'hFFFF_FFFF); wr(100, 32'hFFFF_FFFF);
    rd(18); rd(19); rd(22); rd(23); rd(24); rd(25); rd(4); rd(5); rd(7);
    rd(30); rd(64); rd(200);
    wr(21, 32'h0); wr(7, 32'h0);

    cur_req = "R12";
    wr(21, 32'h0000_0001);
    src_in = 64'd1;
    rd(16);
    rd(19);
    src_in = '0; idle(1); rd(19);
    src_in = 64'd1; idle(1); rd(19); rd(16); rd(19);

    finish_run();
  end
endmodule